// File: doc/BRIEF.md
# Operand Bypass and Load-Use Interlock

This block is the hazard control for a five-stage integer pipeline with 32-bit fixed-format instructions. It looks at the instruction words in the ID/EX, EX/MEM and MEM/WB pipeline registers. From them it chooses where each of three operands comes from. The three operands are ALU input A, ALU input B and the data to be stored. Each can come from the register-file read, from the ALU result parked in EX/MEM, or from the write-back value in MEM/WB.

A load whose result is needed by the very next instruction cannot be bypassed in time. For that case the block raises a stall. The stall holds the fetch side (the IF/ID register, and with it the program counter) for one cycle and places a bubble into ID/EX. After the bubble, the loaded value reaches the dependent instruction through the MEM/WB bypass.

The top module contains a thin shell of instruction-word pipeline registers, so that the stall and bubble behaviour can be seen at its ports. The register file, ALU and memories sit outside the block and appear here only as register fields.

Top module: `hazard_ctrl_unit`

## Requirements
- R1: After synchronous reset, every stage register holds the all-zero word, stall is 0, and all three selects read 0.
- R2: A select uses code 0 for the register file, code 1 for EX/MEM and code 2 for MEM/WB; code 3 never appears. Code 1 is chosen when the EX/MEM instruction is a register-register or register-immediate operation whose destination equals the source that the EX-stage instruction reads.
- R3: When the EX/MEM instruction does not match and the MEM/WB instruction writes a register equal to the source, the select is code 2. Here the MEM/WB writer may be a register-register, register-immediate or load instruction.
- R4: When both EX/MEM and MEM/WB hold a matching writer, the select is code 1, so the younger result wins.
- R5: Register index 0 never takes part in a bypass match or a stall match.
- R6: Field positions and producers are fixed as follows. The opcode is word bits 31:26. Source 1 is bits 25:21 and source 2 is bits 20:16. Opcode 0x00 is register-register, and its destination is bits 15:11. Opcodes whose top three bits are 001 are register-immediate, and opcode 0x23 is a load; both write the register in bits 20:16. Opcode 0x2B is a store and 0x04/0x05 are branches. Stores, branches and all other opcodes never write a register.
- R7: ALU input B is bypassed only for register-register instructions. For a store, source 1 (the base) drives the ALU-A select and source 2 (the data) drives the store-data select. Both can be bypassed in the same cycle.
- R8: The stall is 1 exactly when the EX-stage instruction is a load with a nonzero destination that the ID-stage instruction reads, either as source 1 or as the source 2 of a register-register or store instruction. An ALU producer never causes a stall. While the stall is 1, the IF/ID word is held and ID/EX receives the all-zero word, and the stall lasts a single cycle.
- R9: Two cycles after a stall, the dependent instruction sits in EX with the load in MEM/WB. At that point its matching operand select is code 2. A load held in EX/MEM is never selected with code 1.
- R10: A producer three instructions ahead of the consumer is no longer bypassed, and the select reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_word | input | 32 | Instruction word offered by fetch; taken into IF/ID when not stalled |
| stall | output | 1 | Load-use interlock: hold fetch and IF/ID, bubble into ID/EX |
| sel_alu_a | output | 2 | Source select for ALU input A |
| sel_alu_b | output | 2 | Source select for ALU input B |
| sel_st_data | output | 2 | Source select for the store-data path |

## Verification
Some behaviours are checked by assertions on every cycle:
- a stall lasts one cycle, IF/ID is held through it, and a bubble follows it;
- two cycles after a stall, some operand selects MEM/WB;
- a load parked in EX/MEM is never picked as a bypass source;
- register 0 never gets bypassed on input A;
- select code 3 never appears.

Other behaviours can only be shown by the bench's instruction sequences, because they depend on which field a given opcode uses as its destination. These are the class-dependent destination decode, the age priority between the two bypass points, the dual bypass of a store's base and data, and the absence of a bypass once the producer has left MEM/WB.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    localparam int unsigned INSTR_W   = 32;
    localparam int unsigned REG_IDX_W = 5;
    localparam int unsigned OPC_W     = 6;
    localparam int unsigned OPC_LSB   = INSTR_W - OPC_W;
    localparam int unsigned SRC1_LSB  = OPC_LSB - REG_IDX_W;
    localparam int unsigned SRC2_LSB  = SRC1_LSB - REG_IDX_W;
    localparam int unsigned DSTR_LSB  = SRC2_LSB - REG_IDX_W;

    localparam logic [OPC_W-1:0] OPC_REGREG = 6'h00;
    localparam logic [OPC_W-1:0] OPC_LOAD   = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STORE  = 6'h2B;
    localparam logic [OPC_W-1:0] OPC_BRZ    = 6'h04;
    localparam logic [OPC_W-1:0] OPC_BRNZ   = 6'h05;
    localparam logic [2:0]       OPC_IMM_GRP = 3'b001;

    typedef logic [REG_IDX_W-1:0] ridx_t;
    typedef logic [INSTR_W-1:0]   iword_t;

    localparam iword_t BUBBLE_WORD = '0;

    typedef enum logic [2:0] {
        CLS_OTHER,
        CLS_REGREG,
        CLS_REGIMM,
        CLS_LOAD,
        CLS_STORE,
        CLS_BRANCH
    } iclass_e;

    typedef enum logic [1:0] {
        OPSEL_REGFILE = 2'd0,
        OPSEL_EXMEM   = 2'd1,
        OPSEL_MEMWB   = 2'd2
    } opsel_e;

    typedef struct packed {
        iclass_e cls;
        ridx_t   src1;
        ridx_t   src2;
        ridx_t   dst;
        logic    use_src1;
        logic    use_src2_alu;
        logic    use_src2_st;
        logic    writes;
        logic    result_in_ex;
    } idec_t;

    function automatic iclass_e classify(iword_t w);
        logic [OPC_W-1:0] op;
        iclass_e c;
        op = w[OPC_LSB +: OPC_W];
        if (op == OPC_REGREG)                      c = CLS_REGREG;
        else if (op[OPC_W-1 -: 3] == OPC_IMM_GRP)  c = CLS_REGIMM;
        else if (op == OPC_LOAD)                   c = CLS_LOAD;
        else if (op == OPC_STORE)                  c = CLS_STORE;
        else if (op == OPC_BRZ || op == OPC_BRNZ)  c = CLS_BRANCH;
        else                                       c = CLS_OTHER;
        return c;
    endfunction

    function automatic idec_t decode_word(iword_t w);
        idec_t d;
        d.cls          = classify(w);
        d.src1         = w[SRC1_LSB +: REG_IDX_W];
        d.src2         = w[SRC2_LSB +: REG_IDX_W];
        d.dst          = '0;
        d.use_src1     = 1'b0;
        d.use_src2_alu = 1'b0;
        d.use_src2_st  = 1'b0;
        d.writes       = 1'b0;
        d.result_in_ex = 1'b0;
        unique case (d.cls)
            CLS_REGREG: begin
                d.dst          = w[DSTR_LSB +: REG_IDX_W];
                d.use_src1     = 1'b1;
                d.use_src2_alu = 1'b1;
                d.writes       = 1'b1;
                d.result_in_ex = 1'b1;
            end
            CLS_REGIMM: begin
                d.dst          = w[SRC2_LSB +: REG_IDX_W];
                d.use_src1     = 1'b1;
                d.writes       = 1'b1;
                d.result_in_ex = 1'b1;
            end
            CLS_LOAD: begin
                d.dst          = w[SRC2_LSB +: REG_IDX_W];
                d.use_src1     = 1'b1;
                d.writes       = 1'b1;
            end
            CLS_STORE: begin
                d.use_src1     = 1'b1;
                d.use_src2_st  = 1'b1;
            end
            CLS_BRANCH: begin
                d.use_src1     = 1'b1;
            end
            default: begin
            end
        endcase
        return d;
    endfunction

    // A match needs a live reader, a live writer and a nonzero index.
    function automatic logic reg_match(ridx_t src, logic used, ridx_t dst, logic wr);
        return used && wr && (src != '0) && (src == dst);
    endfunction

endpackage

// File: rtl/hzd_decode.sv
module hzd_decode
    import hzd_pkg::*;
(
    input  iword_t word,
    output idec_t  dec
);
    always_comb begin
        dec = decode_word(word);
    end
endmodule

// File: rtl/hzd_operand_sel.sv
module hzd_operand_sel
    import hzd_pkg::*;
(
    input  ridx_t  src,
    input  logic   used,
    input  idec_t  exmem_dec,
    input  idec_t  memwb_dec,
    output opsel_e sel
);
    logic near_hit;
    logic far_hit;

    always_comb begin
        // A load in EX/MEM has no data yet and cannot be a source here.
        near_hit = reg_match(src, used, exmem_dec.dst,
                             exmem_dec.writes && exmem_dec.result_in_ex);
        far_hit  = reg_match(src, used, memwb_dec.dst, memwb_dec.writes);
        if (near_hit)     sel = OPSEL_EXMEM;
        else if (far_hit) sel = OPSEL_MEMWB;
        else              sel = OPSEL_REGFILE;
    end
endmodule

// File: rtl/hzd_load_interlock.sv
module hzd_load_interlock
    import hzd_pkg::*;
(
    input  idec_t id_dec,
    input  idec_t ex_dec,
    output logic  stall
);
    logic ex_is_load;
    logic hit_src1;
    logic hit_src2;

    always_comb begin
        ex_is_load = ex_dec.writes && !ex_dec.result_in_ex;
        hit_src1   = reg_match(id_dec.src1, id_dec.use_src1, ex_dec.dst, ex_is_load);
        hit_src2   = reg_match(id_dec.src2, id_dec.use_src2_alu || id_dec.use_src2_st,
                               ex_dec.dst, ex_is_load);
        stall      = hit_src1 || hit_src2;
    end
endmodule

// File: rtl/hazard_ctrl_unit.sv
module hazard_ctrl_unit
    import hzd_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [INSTR_W-1:0]  fetch_word,
    output logic                stall,
    output logic [1:0]          sel_alu_a,
    output logic [1:0]          sel_alu_b,
    output logic [1:0]          sel_st_data
);
    localparam int unsigned N_STAGE = 4;
    localparam int unsigned N_OPND  = 3;
    localparam int unsigned ST_ID   = 0;
    localparam int unsigned ST_EX   = 1;
    localparam int unsigned ST_MEM  = 2;
    localparam int unsigned ST_WB   = 3;

    iword_t ifid_q;
    iword_t idex_q;
    iword_t exmem_q;
    iword_t memwb_q;

    iword_t stage_w [N_STAGE];
    idec_t  stage_d [N_STAGE];

    ridx_t  op_src [N_OPND];
    logic   op_use [N_OPND];
    opsel_e op_sel [N_OPND];

    logic   stall_c;

    // Instruction-word shell: IF/ID holds on a stall, ID/EX takes a bubble.
    always_ff @(posedge clk) begin
        if (rst) begin
            ifid_q  <= BUBBLE_WORD;
            idex_q  <= BUBBLE_WORD;
            exmem_q <= BUBBLE_WORD;
            memwb_q <= BUBBLE_WORD;
        end else begin
            if (!stall_c) ifid_q <= fetch_word;
            idex_q  <= stall_c ? BUBBLE_WORD : ifid_q;
            exmem_q <= idex_q;
            memwb_q <= exmem_q;
        end
    end

    assign stage_w[ST_ID]  = ifid_q;
    assign stage_w[ST_EX]  = idex_q;
    assign stage_w[ST_MEM] = exmem_q;
    assign stage_w[ST_WB]  = memwb_q;

    for (genvar s = 0; s < N_STAGE; s++) begin : g_dec
        hzd_decode u_dec (
            .word (stage_w[s]),
            .dec  (stage_d[s])
        );
    end

    // Operand 0: ALU A, operand 1: ALU B, operand 2: store data.
    assign op_src[0] = stage_d[ST_EX].src1;
    assign op_use[0] = stage_d[ST_EX].use_src1;
    assign op_src[1] = stage_d[ST_EX].src2;
    assign op_use[1] = stage_d[ST_EX].use_src2_alu;
    assign op_src[2] = stage_d[ST_EX].src2;
    assign op_use[2] = stage_d[ST_EX].use_src2_st;

    for (genvar k = 0; k < N_OPND; k++) begin : g_opnd
        hzd_operand_sel u_sel (
            .src       (op_src[k]),
            .used      (op_use[k]),
            .exmem_dec (stage_d[ST_MEM]),
            .memwb_dec (stage_d[ST_WB]),
            .sel       (op_sel[k])
        );
    end

    hzd_load_interlock u_lock (
        .id_dec (stage_d[ST_ID]),
        .ex_dec (stage_d[ST_EX]),
        .stall  (stall_c)
    );

    assign stall       = stall_c;
    assign sel_alu_a   = op_sel[0];
    assign sel_alu_b   = op_sel[1];
    assign sel_st_data = op_sel[2];

endmodule

// File: rtl/hazard_ctrl_unit_chk.sv
module hazard_ctrl_unit_chk
    import hzd_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               stall,
    input logic [1:0]         sel_a,
    input logic [1:0]         sel_b,
    input logic [1:0]         sel_st,
    input logic [INSTR_W-1:0] ifid_w,
    input logic [INSTR_W-1:0] idex_w,
    input logic [INSTR_W-1:0] exmem_w
);
    // R8
    stall_single_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> !stall);

    // R8
    bubble_after_stall_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> (idex_w == '0));

    // R8
    ifid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stall |=> $stable(ifid_w));

    // R9
    post_stall_fwd_chk: assert property (@(posedge clk) disable iff (rst)
        stall |-> ##2 (sel_a == 2'd2 || sel_b == 2'd2 || sel_st == 2'd2));

    // R9
    load_not_from_exmem_chk: assert property (@(posedge clk) disable iff (rst)
        (exmem_w[OPC_LSB +: OPC_W] == OPC_LOAD)
            |-> (sel_a != 2'd1 && sel_b != 2'd1 && sel_st != 2'd1));

    // R5
    zero_reg_a_chk: assert property (@(posedge clk) disable iff (rst)
        (idex_w[SRC1_LSB +: REG_IDX_W] == '0) |-> (sel_a == 2'd0));

    // R2
    sel_code_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_a != 2'd3) && (sel_b != 2'd3) && (sel_st != 2'd3));
endmodule

bind hazard_ctrl_unit hazard_ctrl_unit_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .stall   (stall),
    .sel_a   (sel_alu_a),
    .sel_b   (sel_alu_b),
    .sel_st  (sel_st_data),
    .ifid_w  (ifid_q),
    .idex_w  (idex_q),
    .exmem_w (exmem_q)
);

// File: tb/test_hazard_ctrl_unit.sv
`timescale 1ns/1ps
module test_hazard_ctrl_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] fetch_word = '0;
    logic        stall;
    logic [1:0]  sel_alu_a, sel_alu_b, sel_st_data;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    logic [31:0] m_ifid = '0, m_idex = '0, m_exmem = '0, m_memwb = '0;

    always #10 clk = ~clk;

    hazard_ctrl_unit i_hazard_ctrl_unit (
        .clk         (clk),
        .rst         (rst),
        .fetch_word  (fetch_word),
        .stall       (stall),
        .sel_alu_a   (sel_alu_a),
        .sel_alu_b   (sel_alu_b),
        .sel_st_data (sel_st_data)
    );

    // Instruction builders (encodings per R6)
    function automatic logic [31:0] rr(int rd, int s1, int s2);
        return {6'h00, 5'(s1), 5'(s2), 5'(rd), 11'h0};
    endfunction
    function automatic logic [31:0] ri(int rt, int s1);
        return {6'h08, 5'(s1), 5'(rt), 16'h0064};
    endfunction
    function automatic logic [31:0] ld(int rt, int s1);
        return {6'h23, 5'(s1), 5'(rt), 16'h0004};
    endfunction
    function automatic logic [31:0] st(int base, int data);
        return {6'h2B, 5'(base), 5'(data), 16'h0008};
    endfunction
    function automatic logic [31:0] br(int s1);
        return {6'h04, 5'(s1), 5'd0, 16'h0010};
    endfunction
    function automatic logic [31:0] oth(int a, int b);
        return {6'h3F, 5'(a), 5'(b), 16'h0000};
    endfunction

    // Reference model from the requirements
    function automatic int kind(logic [31:0] w);
        if (w[31:26] == 6'h00) return 1;
        if (w[31:29] == 3'b001) return 2;
        if (w[31:26] == 6'h23) return 3;
        if (w[31:26] == 6'h2B) return 4;
        if (w[31:26] == 6'h04 || w[31:26] == 6'h05) return 5;
        return 0;
    endfunction
    function automatic int f1(logic [31:0] w); return int'(w[25:21]); endfunction
    function automatic int f2(logic [31:0] w); return int'(w[20:16]); endfunction
    function automatic int dst_of(logic [31:0] w);
        if (kind(w) == 1) return int'(w[15:11]);
        if (kind(w) == 2 || kind(w) == 3) return f2(w);
        return 0;
    endfunction
    function automatic bit alu_wr(logic [31:0] w); return kind(w) == 1 || kind(w) == 2; endfunction
    function automatic bit any_wr(logic [31:0] w); return kind(w) >= 1 && kind(w) <= 3; endfunction
    function automatic bit reads1(logic [31:0] w); return kind(w) != 0; endfunction

    function automatic int m_sel(int src, bit used, logic [31:0] em, logic [31:0] mw);
        if (!used || src == 0) return 0;
        if (alu_wr(em) && dst_of(em) == src) return 1;
        if (any_wr(mw) && dst_of(mw) == src) return 2;
        return 0;
    endfunction
    function automatic bit m_stall(logic [31:0] id, logic [31:0] ex);
        int d;
        if (kind(ex) != 3) return 1'b0;
        d = dst_of(ex);
        if (d == 0) return 1'b0;
        if (reads1(id) && f1(id) == d) return 1'b1;
        if ((kind(id) == 1 || kind(id) == 4) && f2(id) == d) return 1'b1;
        return 1'b0;
    endfunction
    function automatic string seltag(int e);
        if (e == 1) return "R2";
        if (e == 2) return "R3";
        return "R10";
    endfunction

    task automatic chk(string tag, int got, int exp, string what);
        total++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic compare_all();
        int ea, eb, es;
        ea = m_sel(f1(m_idex), reads1(m_idex), m_exmem, m_memwb);
        eb = m_sel(f2(m_idex), kind(m_idex) == 1, m_exmem, m_memwb);
        es = m_sel(f2(m_idex), kind(m_idex) == 4, m_exmem, m_memwb);
        chk("R8", int'(stall), int'(m_stall(m_ifid, m_idex)), "stall");
        chk(seltag(ea), int'(sel_alu_a), ea, "sel_alu_a");
        chk(seltag(eb), int'(sel_alu_b), eb, "sel_alu_b");
        chk(seltag(es), int'(sel_st_data), es, "sel_st_data");
    endtask

    // One clock: check at the falling edge, drive, update the model.
    task automatic cyc(logic [31:0] w);
        bit s;
        compare_all();
        fetch_word = w;
        @(posedge clk);
        s = m_stall(m_ifid, m_idex);
        m_memwb = m_exmem;
        m_exmem = m_idex;
        m_idex  = s ? 32'h0 : m_ifid;
        if (!s) m_ifid = w;
        @(negedge clk);
    endtask

    task automatic push(logic [31:0] w);
        while (m_stall(m_ifid, m_idex)) cyc(w);
        cyc(w);
    endtask

    task automatic flush();
        for (int i = 0; i < 4; i++) push(32'h0);
    endtask

    task automatic expect_sel(string tag, int a, int b, int s);
        chk(tag, int'(sel_alu_a), a, "sel_alu_a");
        chk(tag, int'(sel_alu_b), b, "sel_alu_b");
        chk(tag, int'(sel_st_data), s, "sel_st_data");
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1", int'(stall), 0, "stall");
        expect_sel("R1", 0, 0, 0);

        // R2 / R7: ALU result bypassed to both store base and store data
        flush();
        push(rr(1, 2, 3)); push(st(1, 1)); push(32'h0);
        expect_sel("R7", 1, 0, 1);
        // R7: ALU input B bypass for register-register, R5 source 0 on A
        flush();
        push(rr(1, 2, 3)); push(rr(5, 0, 1)); push(32'h0);
        expect_sel("R7", 0, 1, 0);

        // R4: both stages match, younger wins
        flush();
        push(rr(1, 2, 3)); push(ri(1, 0)); push(rr(5, 1, 1)); push(32'h0);
        expect_sel("R4", 1, 1, 0);

        // R5: destination r0 never matches, load to r0 never stalls
        flush();
        push(rr(0, 1, 2)); push(rr(3, 0, 0)); push(32'h0);
        expect_sel("R5", 0, 0, 0);
        flush();
        push(ld(0, 1)); push(rr(3, 0, 0));
        chk("R5", int'(stall), 0, "stall");

        // R6: register-register writes bits 15:11, not bits 20:16
        flush();
        push(rr(7, 1, 6)); push(rr(8, 6, 7)); push(32'h0);
        expect_sel("R6", 0, 1, 0);
        // R6: store never a producer
        flush();
        push(st(2, 4)); push(ri(9, 4)); push(32'h0);
        expect_sel("R6", 0, 0, 0);
        // R6: register-immediate writes bits 20:16
        flush();
        push(ri(4, 1)); push(st(4, 4)); push(32'h0);
        expect_sel("R6", 1, 0, 1);
        // R6: branch never a producer
        flush();
        push(br(3)); push(rr(2, 0, 3)); push(32'h0);
        expect_sel("R6", 0, 0, 0);

        // R3: MEM/WB bypass; R10: three ahead not bypassed
        flush();
        push(rr(1, 2, 3)); push(oth(0, 0)); push(rr(5, 1, 0)); push(32'h0);
        expect_sel("R3", 2, 0, 0);
        flush();
        push(rr(1, 2, 3)); push(oth(0, 0)); push(oth(0, 0)); push(rr(5, 1, 0)); push(32'h0);
        expect_sel("R10", 0, 0, 0);

        // R8: ALU producer does not stall
        flush();
        push(rr(1, 2, 3)); push(rr(4, 1, 1));
        chk("R8", int'(stall), 0, "stall after alu producer");

        // R8 / R9: load-use stall for one cycle, then MEM/WB bypass
        flush();
        push(ld(2, 1)); push(rr(3, 4, 2));
        chk("R8", int'(stall), 1, "stall on load-use");
        cyc(32'h0);
        chk("R8", int'(stall), 0, "stall second cycle");
        cyc(32'h0);
        expect_sel("R9", 0, 2, 0);
        // R9: store data from a load, stall then MEM/WB
        flush();
        push(ld(3, 1)); push(st(1, 3));
        chk("R8", int'(stall), 1, "stall on load-store");
        cyc(32'h0);
        cyc(32'h0);
        expect_sel("R9", 0, 0, 2);

        // Random streams over registers 0..3
        flush();
        for (int n = 0; n < 600; n++) begin
            int c, a, b, d;
            logic [31:0] w;
            c = $urandom_range(0, 5);
            a = $urandom_range(0, 3);
            b = $urandom_range(0, 3);
            d = $urandom_range(0, 3);
            case (c)
                0: w = rr(d, a, b);
                1: w = ri(d, a);
                2: w = ld(d, a);
                3: w = st(a, b);
                4: w = br(a);
                default: w = oth(a, b);
            endcase
            push(w);
        end
        flush();

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule